// File: doc/BRIEF.md
# Programmable down-counting interval timer

This block is a 32-bit interval timer on a single-cycle word bus. Software sets a control word, a reload value and a match value. The counter then steps down once for each tick of a chosen tick source. On reaching zero, the counter either reloads from the reload value or wraps to all ones. A sticky match flag, and an optional interrupt, report each step that lands the counter on the match value.

Each tick source is one external tick-enable input, and a two-bit field in the control word selects one of them. Three mode inputs (debug, wait, stop) can freeze counting unless the matching run-in-mode bit is set. A self-clearing reset bit in the control word clears the counting state over a fixed number of cycles and keeps the rest of the configuration. Reads are combinational from `addr_i`. A write takes effect at the clock edge at which `wr_i` is high.

Top module: `ivl_timer`

## Requirements
- R1: After `rst_ni` is released, the five registers read as follows: control 0, status 0, reload 0xFFFFFFFF, match 0, count 0xFFFFFFFF. `irq_o` is 0.
- R2: The byte offsets are 0x00 control, 0x04 status, 0x08 reload, 0x0C match and 0x10 count. The count is read-only, and a write to offset 0x10 leaves it unchanged.
- R3: Control bit 0 is the run bit. While it is 1 and the selected tick input is high at a clock edge, the count drops by one at that edge. In all other cases the count holds, unless another requirement changes it.
- R4: Control bit 1 is the restart-on-enable bit. When it is set, the clock edge after the run bit goes from 0 to 1 copies the reload value into the count.
- R5: Control bit 3 is the auto-reload bit. When it is set, a step taken from a count of 0 loads the reload value.
- R6: When auto-reload is clear, a step taken from a count of 0 gives 0xFFFFFFFF, and counting continues down from there.
- R7: Control bits 25:24 select the tick source. The value 0 means no source, so the count never steps. The values 1, 2 and 3 select `tick_i[0]`, `tick_i[1]` and `tick_i[2]`.
- R8: Status bit 0 is the match flag. It becomes 1 at the edge where a counting step makes the count equal the match value. Writing 1 to status bit 0 clears the flag, and writing 0 to it has no effect.
- R9: `irq_o` is 1 exactly when the match flag is 1 and control bit 2 (interrupt enable) is 1.
- R10: If a counting step sets the match flag in the same cycle that software writes 1 to clear it, the flag ends up 1.
- R11: When control bit 17 is set, a write to the reload offset also loads the count at the same edge. When bit 17 is clear, the count keeps its value and only later reloads use the new value.
- R12: While `dbg_mode_i`, `wait_mode_i` or `stop_mode_i` is high, counting is frozen unless the matching control bit is set: bit 18 for debug, bit 19 for wait, bit 21 for stop.
- R13: Writing a 1 to control bit 16 starts a soft reset. Bit 16 reads as 1 for 2 cycles and then reads as 0. The reset leaves the count at 0xFFFFFFFF, the reload value at 0xFFFFFFFF, the match value at 0 and the flag at 0. The other control bits written in that word are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 5 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| tick_i | input | 3 | One tick-enable input per tick source |
| dbg_mode_i | input | 1 | Debug mode active |
| wait_mode_i | input | 1 | Wait mode active |
| stop_mode_i | input | 1 | Stop mode active |
| irq_o | output | 1 | Match interrupt |

## Verification
Every register write, counter step, restart, load-through and flag change appears at the first clock edge after the stimulus. It can therefore be read through `rdata_o` on the next falling edge. The one exception is restart-on-enable, which lags the control write by one more edge. The soft-reset bit is sampled on three falling edges in a row to catch the 2-cycle busy window exactly. The bench drives all stimulus and samples all results on falling edges, and before each read it waits the cycle count worked out above.

// File: rtl/ivl_timer_pkg.sv
package ivl_timer_pkg;
  localparam int unsigned DW    = 32;
  localparam int unsigned AW    = 5;
  localparam int unsigned SRC_W = 2;

  localparam logic [AW-1:0] OFS_CTRL = 5'h00;
  localparam logic [AW-1:0] OFS_STAT = 5'h04;
  localparam logic [AW-1:0] OFS_LOAD = 5'h08;
  localparam logic [AW-1:0] OFS_CMP  = 5'h0C;
  localparam logic [AW-1:0] OFS_CNT  = 5'h10;

  localparam int unsigned B_RUN   = 0;
  localparam int unsigned B_RSTRT = 1;
  localparam int unsigned B_IRQEN = 2;
  localparam int unsigned B_ARLD  = 3;
  localparam int unsigned B_SRST  = 16;
  localparam int unsigned B_THRU  = 17;
  localparam int unsigned B_DBG   = 18;
  localparam int unsigned B_WAIT  = 19;
  localparam int unsigned B_STOP  = 21;
  localparam int unsigned B_SRC   = 24;

  typedef struct packed {
    logic [SRC_W-1:0] src;
    logic stop_run;
    logic wait_run;
    logic dbg_run;
    logic load_thru;
    logic auto_rld;
    logic irq_en;
    logic restart_en;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/ivl_timer_regs.sv
module ivl_timer_regs
  import ivl_timer_pkg::*;
#(
  parameter int unsigned RST_CYC = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output ctrl_t         ctrl_o,
  output logic [DW-1:0] load_o,
  output logic [DW-1:0] cmp_o,
  output logic          busy_o,
  output logic          load_wr_o,
  output logic          clr_o
);
  localparam int unsigned BW = $clog2(RST_CYC + 1);

  logic [BW-1:0] bcnt_q;

  assign busy_o    = (bcnt_q != '0);
  assign load_wr_o = wr_i && (addr_i == OFS_LOAD) && !busy_o;
  assign clr_o     = wr_i && (addr_i == OFS_STAT) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '0;
      load_o <= '1;
      cmp_o  <= '0;
      bcnt_q <= '0;
    end else begin
      if (wr_i && addr_i == OFS_CTRL) begin
        ctrl_o.run        <= wdata_i[B_RUN];
        ctrl_o.restart_en <= wdata_i[B_RSTRT];
        ctrl_o.irq_en     <= wdata_i[B_IRQEN];
        ctrl_o.auto_rld   <= wdata_i[B_ARLD];
        ctrl_o.load_thru  <= wdata_i[B_THRU];
        ctrl_o.dbg_run    <= wdata_i[B_DBG];
        ctrl_o.wait_run   <= wdata_i[B_WAIT];
        ctrl_o.stop_run   <= wdata_i[B_STOP];
        ctrl_o.src        <= wdata_i[B_SRC +: SRC_W];
      end
      if (busy_o) begin
        bcnt_q <= bcnt_q - 1'b1;
        load_o <= '1;
        cmp_o  <= '0;
      end else begin
        if (wr_i && addr_i == OFS_CTRL && wdata_i[B_SRST]) bcnt_q <= BW'(RST_CYC);
        if (load_wr_o) load_o <= wdata_i;
        if (wr_i && addr_i == OFS_CMP) cmp_o <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/ivl_timer_count.sv
module ivl_timer_count
  import ivl_timer_pkg::*;
#(
  parameter int unsigned NUM_SRC = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  ctrl_t              ctrl_i,
  input  logic [DW-1:0]      load_i,
  input  logic               busy_i,
  input  logic               load_wr_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic [NUM_SRC-1:0] tick_i,
  input  logic               dbg_mode_i,
  input  logic               wait_mode_i,
  input  logic               stop_mode_i,
  output logic [DW-1:0]      cnt_o,
  output logic [DW-1:0]      cnt_d_o,
  output logic               adv_o,
  output logic               restart_o,
  output logic               thru_o
);
  logic run_prev_q;
  logic tick_sel;
  logic mode_ok;

  always_comb begin
    tick_sel = 1'b0;
    for (int s = 0; s < NUM_SRC; s++)
      if (int'(ctrl_i.src) == s + 1) tick_sel = tick_i[s];
  end

  assign mode_ok = !(dbg_mode_i  && !ctrl_i.dbg_run)  &&
                   !(wait_mode_i && !ctrl_i.wait_run) &&
                   !(stop_mode_i && !ctrl_i.stop_run);

  assign restart_o = ctrl_i.run && !run_prev_q && ctrl_i.restart_en;
  assign thru_o    = load_wr_i && ctrl_i.load_thru;
  assign adv_o     = !busy_i && !thru_o && !restart_o &&
                     ctrl_i.run && tick_sel && mode_ok;

  always_comb begin
    cnt_d_o = cnt_o;
    if (busy_i)                          cnt_d_o = '1;
    else if (thru_o)                     cnt_d_o = wdata_i;
    else if (restart_o)                  cnt_d_o = load_i;
    else if (adv_o) begin
      if (cnt_o != '0)                   cnt_d_o = cnt_o - 1'b1;
      else if (ctrl_i.auto_rld)          cnt_d_o = load_i;
      else                               cnt_d_o = '1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o      <= '1;
      run_prev_q <= 1'b0;
    end else begin
      cnt_o      <= cnt_d_o;
      run_prev_q <= ctrl_i.run;
    end
  end
endmodule

// File: rtl/ivl_timer_flag.sv
module ivl_timer_flag
  import ivl_timer_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  input  logic [DW-1:0] cnt_d_i,
  input  logic [DW-1:0] cmp_i,
  input  logic          busy_i,
  input  logic          clr_i,
  output logic          flag_o
);
  logic hit;
  assign hit = adv_i && (cnt_d_i == cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_o <= 1'b0;
    else if (busy_i)  flag_o <= 1'b0;
    else if (hit)     flag_o <= 1'b1;  // set beats clear
    else if (clr_i)   flag_o <= 1'b0;
  end
endmodule

// File: rtl/ivl_timer.sv
module ivl_timer
  import ivl_timer_pkg::*;
#(
  parameter int unsigned NUM_SRC = 3,
  parameter int unsigned RST_CYC = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  input  logic [NUM_SRC-1:0] tick_i,
  input  logic               dbg_mode_i,
  input  logic               wait_mode_i,
  input  logic               stop_mode_i,
  output logic               irq_o
);
  ctrl_t         ctrl;
  logic [DW-1:0] load_q, cmp_q, cnt_q, cnt_d;
  logic          busy, load_wr, clr, adv, restart, thru, flag_q;
  logic [DW-1:0] ctrl_word;

  ivl_timer_regs #(.RST_CYC(RST_CYC)) u_regs (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .ctrl_o(ctrl), .load_o(load_q), .cmp_o(cmp_q),
    .busy_o(busy), .load_wr_o(load_wr), .clr_o(clr)
  );

  ivl_timer_count #(.NUM_SRC(NUM_SRC)) u_count (
    .clk_i, .rst_ni, .ctrl_i(ctrl), .load_i(load_q), .busy_i(busy),
    .load_wr_i(load_wr), .wdata_i, .tick_i, .dbg_mode_i, .wait_mode_i,
    .stop_mode_i, .cnt_o(cnt_q), .cnt_d_o(cnt_d), .adv_o(adv),
    .restart_o(restart), .thru_o(thru)
  );

  ivl_timer_flag u_flag (
    .clk_i, .rst_ni, .adv_i(adv), .cnt_d_i(cnt_d), .cmp_i(cmp_q),
    .busy_i(busy), .clr_i(clr), .flag_o(flag_q)
  );

  always_comb begin
    ctrl_word                = '0;
    ctrl_word[B_RUN]         = ctrl.run;
    ctrl_word[B_RSTRT]       = ctrl.restart_en;
    ctrl_word[B_IRQEN]       = ctrl.irq_en;
    ctrl_word[B_ARLD]        = ctrl.auto_rld;
    ctrl_word[B_SRST]        = busy;
    ctrl_word[B_THRU]        = ctrl.load_thru;
    ctrl_word[B_DBG]         = ctrl.dbg_run;
    ctrl_word[B_WAIT]        = ctrl.wait_run;
    ctrl_word[B_STOP]        = ctrl.stop_run;
    ctrl_word[B_SRC +: SRC_W] = ctrl.src;
  end

  always_comb begin
    unique case (addr_i)
      OFS_CTRL: rdata_o = ctrl_word;
      OFS_STAT: rdata_o = {{(DW-1){1'b0}}, flag_q};
      OFS_LOAD: rdata_o = load_q;
      OFS_CMP:  rdata_o = cmp_q;
      OFS_CNT:  rdata_o = cnt_q;
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o = flag_q && ctrl.irq_en;
endmodule

// File: rtl/ivl_timer_chk.sv
module ivl_timer_chk
  import ivl_timer_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          adv_i,
  input logic          busy_i,
  input logic          restart_i,
  input logic          thru_i,
  input logic          auto_rld_i,
  input logic [DW-1:0] cnt_i,
  input logic [DW-1:0] load_i,
  input logic          flag_i,
  input logic          irq_i
);
  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && cnt_i != '0 |=> cnt_i == $past(cnt_i) - 1'b1);

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i && !busy_i && !restart_i && !thru_i |=> $stable(cnt_i));

  p_reload_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && cnt_i == '0 && auto_rld_i |=> cnt_i == $past(load_i));

  p_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && cnt_i == '0 && !auto_rld_i |=> cnt_i == '1);

  p_flag_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_i) |-> $past(adv_i));

  p_irq_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> flag_i);

  p_srst_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> cnt_i == '1 && !flag_i);
endmodule

bind ivl_timer ivl_timer_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(adv), .busy_i(busy),
  .restart_i(restart), .thru_i(thru), .auto_rld_i(ctrl.auto_rld),
  .cnt_i(cnt_q), .load_i(load_q), .flag_i(flag_q), .irq_i(irq_o)
);

// File: tb/ivl_timer_tb.sv
module ivl_timer_tb_top;
  localparam time CLK_P = 10ns;
  localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_LOAD = 5'h08,
                         A_CMP = 5'h0C, A_CNT = 5'h10;
  localparam logic [31:0] RUN = 32'h1, RSTRT = 32'h2, IRQEN = 32'h4,
                          ARLD = 32'h8, SRST = 32'h1_0000, THRU = 32'h2_0000,
                          DBGR = 32'h4_0000, STOPR = 32'h20_0000;
  localparam logic [31:0] S1 = 32'h0100_0000, S2 = 32'h0200_0000,
                          S3 = 32'h0300_0000;

  logic        clk = 0, rst_n = 0, wr = 0;
  logic [4:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [2:0]  tick = 0;
  logic        dbg_m = 0, wait_m = 0, stop_m = 0, irq;
  int n_chk = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  ivl_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .tick_i(tick), .dbg_mode_i(dbg_m),
    .wait_mode_i(wait_m), .stop_mode_i(stop_m), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d,
                        input logic [2:0] tk = 3'b000);
    @(negedge clk);
    wr = 1; addr = a; wdata = d; tick = tk;
    @(negedge clk);
    wr = 0; tick = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic chk_reg(input string req, input logic [4:0] a,
                         input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic pulse(input logic [2:0] m, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = m;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    chk_reg("R1 ctrl", A_CTRL, 0);
    chk_reg("R1 stat", A_STAT, 0);
    chk_reg("R1 load", A_LOAD, 32'hFFFF_FFFF);
    chk_reg("R1 cmp", A_CMP, 0);
    chk_reg("R1 cnt", A_CNT, 32'hFFFF_FFFF);
    chk("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_restart_step;
    bus_wr(A_LOAD, 10);
    chk_reg("R2 load readback", A_LOAD, 10);
    bus_wr(A_CTRL, RUN | RSTRT | ARLD | S1);
    idle(1);
    chk_reg("R4 restart loads count", A_CNT, 10);
    pulse(3'b001, 3);
    chk_reg("R3 three steps", A_CNT, 7);
    bus_wr(A_CNT, 0);
    chk_reg("R2 count read-only", A_CNT, 7);
  endtask

  task automatic t_reload;
    bus_wr(A_CTRL, 0);
    bus_wr(A_LOAD, 3);
    bus_wr(A_CTRL, RUN | RSTRT | ARLD | S1);
    idle(1);
    pulse(3'b001, 3);
    chk_reg("R5 reached zero", A_CNT, 0);
    pulse(3'b001, 1);
    chk_reg("R5 reload at zero", A_CNT, 3);
  endtask

  task automatic t_wrap;
    bus_wr(A_CTRL, 0);
    bus_wr(A_LOAD, 1);
    bus_wr(A_CTRL, RUN | RSTRT | S1);
    idle(1);
    pulse(3'b001, 2);
    chk_reg("R6 wrap", A_CNT, 32'hFFFF_FFFF);
    pulse(3'b001, 1);
    chk_reg("R6 continue after wrap", A_CNT, 32'hFFFF_FFFE);
  endtask

  task automatic t_source;
    bus_wr(A_CTRL, 0);
    bus_wr(A_LOAD, 20);
    bus_wr(A_CTRL, RUN | RSTRT | ARLD);
    idle(1);
    pulse(3'b111, 2);
    chk_reg("R7 source 0 frozen", A_CNT, 20);
    bus_wr(A_CTRL, RUN | ARLD | S3);
    pulse(3'b011, 2);
    chk_reg("R7 source 3 ignores others", A_CNT, 20);
    pulse(3'b100, 1);
    chk_reg("R7 source 3 steps", A_CNT, 19);
    bus_wr(A_CTRL, RUN | ARLD | S2);
    pulse(3'b010, 1);
    chk_reg("R7 source 2 steps", A_CNT, 18);
  endtask

  task automatic t_match;
    bus_wr(A_CTRL, 0);
    bus_wr(A_LOAD, 8);
    bus_wr(A_CMP, 5);
    bus_wr(A_STAT, 1);
    chk_reg("R8 flag cleared", A_STAT, 0);
    bus_wr(A_CTRL, RUN | RSTRT | ARLD | IRQEN | S1);
    idle(1);
    pulse(3'b001, 2);
    chk_reg("R8 no flag before match", A_STAT, 0);
    chk("R9 irq low", {31'b0, irq}, 0);
    pulse(3'b001, 1);
    chk_reg("R8 flag on match", A_STAT, 1);
    chk("R9 irq high", {31'b0, irq}, 1);
    bus_wr(A_STAT, 0);
    chk_reg("R8 write 0 no effect", A_STAT, 1);
    bus_wr(A_CTRL, RUN | ARLD | S1);
    chk("R9 irq masked", {31'b0, irq}, 0);
    bus_wr(A_STAT, 1);
    chk_reg("R8 write 1 clears", A_STAT, 0);
  endtask

  task automatic t_set_wins;
    bus_wr(A_CMP, 4);
    bus_wr(A_STAT, 1, 3'b001);
    chk_reg("R10 count stepped", A_CNT, 4);
    chk_reg("R10 set beats clear", A_STAT, 1);
  endtask

  task automatic t_thru;
    bus_wr(A_CTRL, RUN | ARLD | THRU | S1);
    bus_wr(A_LOAD, 100);
    chk_reg("R11 load-through", A_CNT, 100);
    bus_wr(A_CTRL, RUN | ARLD | S1);
    bus_wr(A_LOAD, 50);
    chk_reg("R11 no load-through", A_CNT, 100);
    pulse(3'b001, 1);
    chk_reg("R11 keeps counting", A_CNT, 99);
  endtask

  task automatic t_modes;
    dbg_m = 1;
    pulse(3'b001, 1);
    chk_reg("R12 debug freezes", A_CNT, 99);
    bus_wr(A_CTRL, RUN | ARLD | DBGR | S1);
    pulse(3'b001, 1);
    chk_reg("R12 debug run bit", A_CNT, 98);
    dbg_m = 0; stop_m = 1;
    pulse(3'b001, 1);
    chk_reg("R12 stop freezes", A_CNT, 98);
    bus_wr(A_CTRL, RUN | ARLD | STOPR | S1);
    pulse(3'b001, 1);
    chk_reg("R12 stop run bit", A_CNT, 97);
    stop_m = 0;
  endtask

  task automatic t_srst;
    bus_wr(A_CMP, 96);
    pulse(3'b001, 1);
    chk_reg("R13 flag set before reset", A_STAT, 1);
    bus_wr(A_CTRL, SRST | IRQEN | ARLD | S2);
    chk_reg("R13 busy cycle 1", A_CTRL, SRST | IRQEN | ARLD | S2);
    idle(1);
    chk_reg("R13 busy cycle 2", A_CTRL, SRST | IRQEN | ARLD | S2);
    idle(1);
    chk_reg("R13 self-cleared, config kept", A_CTRL, IRQEN | ARLD | S2);
    chk_reg("R13 count", A_CNT, 32'hFFFF_FFFF);
    chk_reg("R13 load", A_LOAD, 32'hFFFF_FFFF);
    chk_reg("R13 cmp", A_CMP, 0);
    chk_reg("R13 flag", A_STAT, 0);
    chk("R13 irq", {31'b0, irq}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_restart_step();
    t_reload();
    t_wrap();
    t_source();
    t_match();
    t_set_wins();
    t_thru();
    t_modes();
    t_srst();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule